// File: doc/BRIEF.md
# Time-Slot Switch Host Access Port

This block sits between a processor bus and the memories of a time-slot switch. The processor sees a 64-location window on a 6-bit address bus. The top half of the window is a paged view of one of three memory banks: the data memory, which holds received samples, and the low and high halves of the connection memory. The bottom half of the window always reaches a single 8-bit control register. That register chooses which bank and which serial stream the paged half reaches. The low five address bits give the channel within that stream.

For each access the block drives a bank code, a stream index, a channel index and per-bank write enables toward the memories. It also returns registered read data with a one-cycle valid pulse. A split mode sends reads to the data memory and writes to the low connection memory, so a host can inspect incoming samples and program connections without rewriting the control register. Two mode bits of the register are exported to the switching core: a global message flag and the split flag.

Top module: `tsw_host_port`

## Requirements
- R1: With address bit 5 at 0, a read or write reaches the control register whatever address bits 4..0 hold, and no memory write enable is raised.
- R2: With address bit 5 at 1, the channel output equals address bits 4..0 and the stream output equals control register bits 2..0.
- R3: Control register bits 4..3 pick the bank for window accesses with split mode off: 01 data memory, 10 connection low, 11 connection high. The bank code output carries this value. A read returns that bank's word. A write to either connection half raises only that half's write enable and presents the write data.
- R4: A window write while the data memory is selected raises no write enable, and both connection memories keep their contents.
- R5: With select code 00 and split mode off, a window read returns 0x00 and a window write raises no write enable. The bank code output is 00.
- R6: With control register bit 7 at 1, window reads come from the data memory and window writes go to the low connection memory, whatever bits 4..3 hold. Control register accesses are unchanged.
- R7: The split output follows control register bit 7, and the message output follows bit 6.
- R8: After reset the control register holds 0x00. A control register read returns all eight bits, and bit 5 always reads 0.
- R9: Read data and a one-cycle read-valid pulse appear on the clock edge after the read strobe. If read and write are both high, only the write takes place and no read-valid follows.
- R10: With chip select low, the read and write strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Chip select, active high |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_addr | input | 6 | Host address; bit 5 chooses the window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| host_rvalid | output | 1 | Read data valid pulse |
| acc_bank | output | 2 | Effective bank code of the current access |
| acc_stream | output | 3 | Stream index toward the memories |
| acc_chan | output | 5 | Channel index toward the memories |
| mem_wdata | output | 8 | Write data toward the memories |
| cml_we | output | 1 | Write enable, connection memory low |
| cmh_we | output | 1 | Write enable, connection memory high |
| dm_rdata | input | 8 | Read word from data memory |
| cml_rdata | input | 8 | Read word from connection memory low |
| cmh_rdata | input | 8 | Read word from connection memory high |
| mode_split | output | 1 | Split-mode flag to the core |
| mode_msg | output | 1 | Global message flag to the core |

## Verification
The assertions assume that the strobes and address are steady for a whole clock cycle and change only between edges. They also assume that the memories answer combinationally for the bank, stream and channel driven in the same cycle. The bench drives every input on the falling edge and holds it across the next rising edge. Its memory models return data combinationally from the indices the block presents, so both assumptions hold for all stimulus.

// File: rtl/tsw_host_pkg.sv
package tsw_host_pkg;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int CHAN_W    = 5;
  localparam int STRM_W    = 3;
  localparam int WIN_BIT   = ADDR_W - 1;
  localparam int SPLIT_BIT = 7;
  localparam int MSG_BIT   = 6;
  localparam int SPARE_BIT = 5;
  localparam int BSEL_LO   = STRM_W;
  localparam int BSEL_W    = 2;

  typedef enum logic [BSEL_W-1:0] {
    BANK_NONE = 2'b00,
    BANK_DM   = 2'b01,
    BANK_CML  = 2'b10,
    BANK_CMH  = 2'b11
  } bank_e;
endpackage

// File: rtl/tsw_rst_sync.sv
module tsw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/tsw_ctrl_reg.sv
module tsw_ctrl_reg
  import tsw_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cr_we,
  input  logic [DATA_W-1:0] cr_wdata,
  output logic [DATA_W-1:0] cr_q
);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << SPARE_BIT);

  logic [DATA_W-1:0] cr_nxt;

  always_comb begin
    cr_nxt = cr_q;
    if (cr_we) cr_nxt = cr_wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cr_q <= '0;
    else if (cr_we) cr_q <= cr_nxt;
  end

  AST_CR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cr_we |=> $stable(cr_q)); // R1
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |=> (cr_q[SPARE_BIT] == 1'b0)); // R8
endmodule

// File: rtl/tsw_bank_route.sv
module tsw_bank_route
  import tsw_host_pkg::*;
(
  input  logic  acc_sel,
  input  logic  acc_rd,
  input  logic  acc_wr,
  input  logic  in_win,
  input  logic  split_on,
  input  bank_e bsel,
  output bank_e eff_bank,
  output logic  wr_cml,
  output logic  wr_cmh,
  output logic  rd_take
);
  logic do_wr;

  always_comb begin
    do_wr   = acc_sel && acc_wr;
    rd_take = acc_sel && acc_rd && !acc_wr;
    if (!acc_sel || !in_win) eff_bank = BANK_NONE;
    else if (split_on)       eff_bank = do_wr ? BANK_CML : BANK_DM;
    else                     eff_bank = bsel;
    wr_cml = do_wr && in_win && (eff_bank == BANK_CML);
    wr_cmh = do_wr && in_win && (eff_bank == BANK_CMH);
  end

  always_comb begin
    AST_CR_NO_MEM_WE: assert (!(acc_sel && !in_win) || (!wr_cml && !wr_cmh)); // R1
    AST_SPLIT_WR_LOW: assert (!(acc_sel && acc_wr && in_win && split_on) || (wr_cml && !wr_cmh)); // R6
    AST_DM_NO_WE: assert (!(!split_on && bsel == BANK_DM) || (!wr_cml && !wr_cmh)); // R4
    AST_IDLE_NO_WE: assert (acc_sel || (!wr_cml && !wr_cmh && !rd_take)); // R10
  end
endmodule

// File: rtl/tsw_read_ret.sv
module tsw_read_ret
  import tsw_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_take,
  input  logic              in_win,
  input  bank_e             eff_bank,
  input  logic [DATA_W-1:0] cr_q,
  input  logic [DATA_W-1:0] dm_word,
  input  logic [DATA_W-1:0] cml_word,
  input  logic [DATA_W-1:0] cmh_word,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] rdata_nxt;

  always_comb begin
    if (!in_win) rdata_nxt = cr_q;
    else begin
      case (eff_bank)
        BANK_DM:  rdata_nxt = dm_word;
        BANK_CML: rdata_nxt = cml_word;
        BANK_CMH: rdata_nxt = cmh_word;
        default:  rdata_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_take;
      if (rd_take) rdata <= rdata_nxt;
    end
  end

  AST_RV_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rvalid); // R9
  AST_RV_ONLY_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> !rvalid); // R9
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && in_win && eff_bank == BANK_NONE) |=> (rdata == '0)); // R5
endmodule

// File: rtl/tsw_host_port.sv
module tsw_host_port
  import tsw_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [BSEL_W-1:0] acc_bank,
  output logic [STRM_W-1:0] acc_stream,
  output logic [CHAN_W-1:0] acc_chan,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              cml_we,
  output logic              cmh_we,
  input  logic [DATA_W-1:0] dm_rdata,
  input  logic [DATA_W-1:0] cml_rdata,
  input  logic [DATA_W-1:0] cmh_rdata,
  output logic              mode_split,
  output logic              mode_msg
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] cr_q;
  logic              in_win;
  logic              cr_we;
  logic              rd_take;
  bank_e             eff_bank;
  bank_e             bsel;

  assign in_win     = host_addr[WIN_BIT];
  assign cr_we      = host_sel && host_wr && !in_win;
  assign bsel       = bank_e'(cr_q[BSEL_LO +: BSEL_W]);
  assign acc_stream = cr_q[STRM_W-1:0];
  assign acc_chan   = host_addr[CHAN_W-1:0];
  assign acc_bank   = eff_bank;
  assign mem_wdata  = host_wdata;
  assign mode_split = cr_q[SPLIT_BIT];
  assign mode_msg   = cr_q[MSG_BIT];

  tsw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tsw_ctrl_reg u_cr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cr_we    (cr_we),
    .cr_wdata (host_wdata),
    .cr_q     (cr_q)
  );

  tsw_bank_route u_route (
    .acc_sel  (host_sel),
    .acc_rd   (host_rd),
    .acc_wr   (host_wr),
    .in_win   (in_win),
    .split_on (mode_split),
    .bsel     (bsel),
    .eff_bank (eff_bank),
    .wr_cml   (cml_we),
    .wr_cmh   (cmh_we),
    .rd_take  (rd_take)
  );

  tsw_read_ret u_ret (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_take  (rd_take),
    .in_win   (in_win),
    .eff_bank (eff_bank),
    .cr_q     (cr_q),
    .dm_word  (dm_rdata),
    .cml_word (cml_rdata),
    .cmh_word (cmh_rdata),
    .rdata    (host_rdata),
    .rvalid   (host_rvalid)
  );

  AST_CR_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_sel && host_wr && !in_win) |=> (mode_msg == $past(host_wdata[MSG_BIT]))); // R7
  AST_NO_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !host_sel |=> $stable(cr_q)); // R10
endmodule

// File: tb/tsw_host_port_bench.sv
`timescale 1ns/1ps
module tsw_host_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid;
  logic [1:0] acc_bank;
  logic [2:0] acc_stream;
  logic [4:0] acc_chan;
  logic [7:0] mem_wdata;
  logic       cml_we, cmh_we;
  logic [7:0] dm_rdata, cml_rdata, cmh_rdata;
  logic       mode_split, mode_msg;

  int checks = 0;
  int fails  = 0;
  logic [7:0] cur_cr = 8'h00;

  logic [7:0] cml_m [256];
  logic [7:0] cmh_m [256];

  always #2 clk = ~clk;

  function automatic logic [7:0] dm_val(input int s, input int c);
    return 8'(((s * 37) + (c * 5)) ^ 8'h5A);
  endfunction

  assign dm_rdata  = dm_val(int'(acc_stream), int'(acc_chan));
  assign cml_rdata = cml_m[{acc_stream, acc_chan}];
  assign cmh_rdata = cmh_m[{acc_stream, acc_chan}];

  always @(posedge clk) begin
    if (cml_we) cml_m[{acc_stream, acc_chan}] <= mem_wdata;
    if (cmh_we) cmh_m[{acc_stream, acc_chan}] <= mem_wdata;
  end

  tsw_host_port u_tsw_host_port (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .acc_bank(acc_bank),
    .acc_stream(acc_stream), .acc_chan(acc_chan), .mem_wdata(mem_wdata),
    .cml_we(cml_we), .cmh_we(cmh_we), .dm_rdata(dm_rdata),
    .cml_rdata(cml_rdata), .cmh_rdata(cmh_rdata),
    .mode_split(mode_split), .mode_msg(mode_msg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d,
                          input bit ecml, input bit ecmh, input string req);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_rd = 1'b0; host_addr = a; host_wdata = d;
    #1;
    chk(cml_we == ecml && cmh_we == ecmh, req, {cml_we, cmh_we}, {ecml, ecmh});
    if (ecml || ecmh) chk(mem_wdata == d, req, mem_wdata, d);
    @(posedge clk);
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
    if (!a[5]) cur_cr = d & 8'hDF;
  endtask

  task automatic do_read(input logic [5:0] a, input logic [7:0] exp,
                         input logic [1:0] ebank, input string req);
    @(negedge clk);
    host_sel = 1'b1; host_rd = 1'b1; host_wr = 1'b0; host_addr = a;
    #1;
    chk(acc_bank == ebank, req, acc_bank, ebank);
    if (a[5]) begin
      chk(acc_chan == a[4:0] && acc_stream == cur_cr[2:0], "R2",
          {acc_stream, acc_chan}, {cur_cr[2:0], a[4:0]});
    end
    @(posedge clk);
    @(negedge clk);
    host_sel = 1'b0; host_rd = 1'b0;
    chk(host_rvalid == 1'b1, "R9", host_rvalid, 1);
    chk(host_rdata == exp, req, host_rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin cml_m[i] = 8'h00; cmh_m[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    chk(mode_split == 0 && mode_msg == 0, "R8", {mode_split, mode_msg}, 0);
    chk(host_rvalid == 0, "R8", host_rvalid, 0);
    do_read(6'h00, 8'h00, 2'b00, "R8");

    // R1 aliasing of the register half, R8 spare bit, R7 mode outputs
    do_write(6'h1F, 8'hFF, 0, 0, "R1");
    #1;
    chk(mode_split == 1 && mode_msg == 1, "R7", {mode_split, mode_msg}, 2'b11);
    do_read(6'h0A, 8'hDF, 2'b00, "R1");
    do_read(6'h15, 8'hDF, 2'b00, "R8");
    do_write(6'h07, 8'h40, 0, 0, "R1");
    #1;
    chk(mode_split == 0 && mode_msg == 1, "R7", {mode_split, mode_msg}, 2'b01);
    do_write(6'h00, 8'h00, 0, 0, "R1");

    // R10 strobes without select
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b1; host_rd = 1'b1; host_addr = 6'h00; host_wdata = 8'h55;
    #1;
    chk(cml_we == 0 && cmh_we == 0, "R10", {cml_we, cmh_we}, 0);
    @(posedge clk);
    @(negedge clk);
    chk(host_rvalid == 0, "R10", host_rvalid, 0);
    host_wr = 1'b0; host_rd = 1'b0;
    do_read(6'h00, 8'h00, 2'b00, "R10");

    // R3 sweep: every stream and channel of all three banks
    for (int s = 0; s < 8; s++) begin
      do_write(6'h00, 8'(8'h10 | s), 0, 0, "R1");
      for (int c = 0; c < 32; c++) do_write(6'(32 + c), 8'(s * 32 + c + 1), 1, 0, "R3");
      do_write(6'h00, 8'(8'h18 | s), 0, 0, "R1");
      for (int c = 0; c < 32; c++) do_write(6'(32 + c), ~8'(s * 32 + c + 1), 0, 1, "R3");
    end
    for (int s = 0; s < 8; s++) begin
      do_write(6'h00, 8'(8'h08 | s), 0, 0, "R1");
      for (int c = 0; c < 32; c++) do_read(6'(32 + c), dm_val(s, c), 2'b01, "R3");
      do_write(6'h00, 8'(8'h10 | s), 0, 0, "R1");
      for (int c = 0; c < 32; c++) do_read(6'(32 + c), 8'(s * 32 + c + 1), 2'b10, "R3");
      do_write(6'h00, 8'(8'h18 | s), 0, 0, "R1");
      for (int c = 0; c < 32; c++) do_read(6'(32 + c), ~8'(s * 32 + c + 1), 2'b11, "R3");
    end

    // R4 write to data memory is dropped
    do_write(6'h00, 8'h0B, 0, 0, "R1");
    do_write(6'h23, 8'hEE, 0, 0, "R4");
    do_write(6'h00, 8'h13, 0, 0, "R1");
    do_read(6'h23, 8'(3 * 32 + 3 + 1), 2'b10, "R4");
    do_write(6'h00, 8'h1B, 0, 0, "R1");
    do_read(6'h23, ~8'(3 * 32 + 3 + 1), 2'b11, "R4");

    // R5 reserved select
    do_write(6'h00, 8'h03, 0, 0, "R1");
    do_read(6'h23, 8'h00, 2'b00, "R5");
    do_write(6'h23, 8'h77, 0, 0, "R5");
    do_write(6'h00, 8'h13, 0, 0, "R1");
    do_read(6'h23, 8'(3 * 32 + 3 + 1), 2'b10, "R5");

    // R6 split mode with bits 4..3 pointing at the high half
    do_write(6'h00, 8'h9D, 0, 0, "R6");
    do_read(6'h29, dm_val(5, 9), 2'b01, "R6");
    do_write(6'h29, 8'hA5, 1, 0, "R6");
    do_read(6'h00, 8'h9D, 2'b00, "R6");
    do_write(6'h00, 8'h15, 0, 0, "R1");
    do_read(6'h29, 8'hA5, 2'b10, "R6");
    do_write(6'h00, 8'h1D, 0, 0, "R1");
    do_read(6'h29, ~8'(5 * 32 + 9 + 1), 2'b11, "R6");

    // R9 read and write together: write only, no valid
    do_write(6'h00, 8'h12, 0, 0, "R1");
    @(negedge clk);
    host_sel = 1'b1; host_rd = 1'b1; host_wr = 1'b1; host_addr = 6'h24; host_wdata = 8'h3C;
    #1;
    chk(cml_we == 1, "R9", cml_we, 1);
    @(posedge clk);
    @(negedge clk);
    host_sel = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
    chk(host_rvalid == 0, "R9", host_rvalid, 0);
    do_read(6'h24, 8'h3C, 2'b10, "R9");
    @(negedge clk);
    chk(host_rvalid == 0, "R9", host_rvalid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule